// File: doc/BRIEF.md
# Dual-Gain Sample Combiner

This block joins two 8-bit readings of one signal into a single 12-bit sample. One reading comes through a unity-gain path. The other comes through a path with sixteen times the gain, so its upper nibble covers the same range as the lower nibble of the unity reading. The combined result takes its most significant nibble from the unity reading and its least significant nibble from the amplified reading.

A mode input chooses how the middle nibble is formed. In join mode, the amplified byte is placed directly under the unity reading's upper nibble. In blend mode, the middle nibble is the average of the two overlapping nibbles. When the two nibbles sit at opposite ends of their range, the block treats the amplified one as having wrapped around. It adds or subtracts one full nibble span before averaging. The corrected middle value may fall outside the nibble range. It then carries into or borrows from the top nibble, and the 12-bit result is clamped at its limits.

The result is registered and appears one clock after the input is accepted.

Top module: `dual_gain_combiner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and sample is 0.
- R2: out_valid equals in_valid from the previous clock cycle.
- R3: When mode is 0 (join), sample equals {lo_smp[7:4], hi_smp[7:0]}.
- R4: When mode is 1 (blend) and no wrap applies, the middle value is floor((lo_smp[3:0] + hi_smp[7:4]) / 2). The result is lo_smp[7:4]*256 + mid*16 + hi_smp[3:0]. Whenever lo_smp[7:4] is between 1 and 14, sample[3:0] equals hi_smp[3:0].
- R5: Upward wrap applies in blend mode when lo_smp[3:0] >= 12 and hi_smp[7:4] < 4. The middle value is then (lo_smp[3:0] + hi_smp[7:4] + 16) / 2, rounded down.
- R6: Downward wrap applies in blend mode when lo_smp[3:0] < 4 and hi_smp[7:4] >= 12. The middle value is then (lo_smp[3:0] + hi_smp[7:4] - 16) / 2, with the division truncating toward zero (for example, -3/2 gives -1).
- R7: A middle value above 15 carries into the top nibble, and a negative middle value borrows from it. The sum lo_smp[7:4]*256 + mid*16 + hi_smp[3:0] is formed with full signed width.
- R8: In blend mode, a sum below 0 gives sample 0, and a sum above 4095 gives sample 4095.
- R9: When in_valid is 0, sample keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The input pair is valid this cycle |
| mode | input | 1 | 0 = join, 1 = blend |
| lo_smp | input | 8 | Unity-gain reading |
| hi_smp | input | 8 | Sixteen-times-gain reading |
| out_valid | output | 1 | sample holds a fresh result |
| sample | output | 12 | Combined 12-bit result |

## Verification
Every one of the 65536 input pairs goes through the block back to back in join mode, and then again in blend mode. The join pass shows the amplified byte is placed unaltered. The blend pass covers every pairing of the overlapping nibbles: the plain average, both wrap regions and the boundary values 3/4 and 11/12 on each side. Directed vectors then isolate a negative odd middle sum, which separates truncation toward zero from rounding down. Other vectors cover a carry into the top nibble, clamping at both ends, and an idle cycle with changed data, which shows the output is held.

// File: rtl/dgc_pkg.sv
package dgc_pkg;
    typedef enum logic {
        MODE_JOIN  = 1'b0,
        MODE_BLEND = 1'b1
    } dgc_mode_e;
endpackage

// File: rtl/dgc_mid_blend.sv
// Forms the corrected middle value from the two overlapping nibbles.
module dgc_mid_blend #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0]        b1_i,
    input  logic [NIB_W-1:0]        b2_i,
    output logic signed [NIB_W+2:0] mid_o
);
    localparam int SW    = NIB_W + 3;
    localparam int SPAN  = 1 << NIB_W;
    localparam int LO_TH = SPAN / 4;
    localparam int HI_TH = SPAN - SPAN / 4;
    localparam logic signed [SW-1:0] SPAN_S = SW'(SPAN);

    logic              up_wrap, dn_wrap;
    logic signed [SW-1:0] sum_s, half_s;

    always_comb begin
        up_wrap = (int'(b1_i) >= HI_TH) && (int'(b2_i) < LO_TH);
        dn_wrap = (int'(b1_i) < LO_TH) && (int'(b2_i) >= HI_TH);
        sum_s   = $signed({{(SW-NIB_W){1'b0}}, b1_i})
                + $signed({{(SW-NIB_W){1'b0}}, b2_i});
        if (up_wrap)
            sum_s = sum_s + SPAN_S;
        else if (dn_wrap)
            sum_s = sum_s - SPAN_S;
        // halve with truncation toward zero
        half_s = sum_s >>> 1;
        if (sum_s[SW-1] && sum_s[0])
            half_s = half_s + SW'(1);
        mid_o = half_s;
    end
endmodule

// File: rtl/dgc_assemble.sv
// Places top, middle and low parts and clamps to the output range.
module dgc_assemble #(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0]        top_i,
    input  logic signed [NIB_W+2:0] mid_i,
    input  logic [NIB_W-1:0]        low_i,
    output logic [3*NIB_W-1:0]      val_o
);
    localparam int SW    = NIB_W + 3;
    localparam int OUT_W = 3 * NIB_W;
    localparam int AW    = OUT_W + 2;

    logic signed [AW-1:0] top_s, mid_s, low_s, acc_s;

    always_comb begin
        top_s = $signed({{(AW-NIB_W){1'b0}}, top_i}) <<< (2 * NIB_W);
        mid_s = $signed({{(AW-SW){mid_i[SW-1]}}, mid_i}) <<< NIB_W;
        low_s = $signed({{(AW-NIB_W){1'b0}}, low_i});
        acc_s = top_s + mid_s + low_s;
        if (acc_s[AW-1])
            val_o = '0;
        else if (|acc_s[AW-2:OUT_W])
            val_o = '1;
        else
            val_o = acc_s[OUT_W-1:0];
    end
endmodule

// File: rtl/dual_gain_combiner.sv
module dual_gain_combiner
    import dgc_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  mode,
    input  logic [2*NIB_W-1:0]    lo_smp,
    input  logic [2*NIB_W-1:0]    hi_smp,
    output logic                  out_valid,
    output logic [3*NIB_W-1:0]    sample
);
    localparam int SMP_W = 2 * NIB_W;
    localparam int OUT_W = 3 * NIB_W;
    localparam int SW    = NIB_W + 3;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] smp;
    } dgc_state_t;

    dgc_state_t st_d, st_q;
    dgc_mode_e  mode_e;

    logic [NIB_W-1:0]     top_nib, b1_nib, b2_nib, low_nib;
    logic signed [SW-1:0] mid_val;
    logic [OUT_W-1:0]     blend_val, join_val;

    assign mode_e  = dgc_mode_e'(mode);
    assign top_nib = lo_smp[SMP_W-1:NIB_W];
    assign b1_nib  = lo_smp[NIB_W-1:0];
    assign b2_nib  = hi_smp[SMP_W-1:NIB_W];
    assign low_nib = hi_smp[NIB_W-1:0];

    dgc_mid_blend #(.NIB_W(NIB_W)) u_mid (
        .b1_i  (b1_nib),
        .b2_i  (b2_nib),
        .mid_o (mid_val)
    );

    dgc_assemble #(.NIB_W(NIB_W)) u_asm (
        .top_i (top_nib),
        .mid_i (mid_val),
        .low_i (low_nib),
        .val_o (blend_val)
    );

    assign join_val = {top_nib, hi_smp};

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.smp = (mode_e == MODE_BLEND) ? blend_val : join_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign sample    = st_q.smp;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_join_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 1'b0) |=>
            sample == $past({lo_smp[SMP_W-1:NIB_W], hi_smp}));
    p_low_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 1'b1 && lo_smp[SMP_W-1:NIB_W] != '0
         && lo_smp[SMP_W-1:NIB_W] != '1) |=>
            sample[NIB_W-1:0] == $past(hi_smp[NIB_W-1:0]));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sample));
endmodule

// File: tb/dual_gain_combiner_bench.sv
`timescale 1ns/1ps
module dual_gain_combiner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [7:0]  lo_smp = '0;
    logic [7:0]  hi_smp = '0;
    logic        out_valid;
    logic [11:0] sample;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    dual_gain_combiner u_dual_gain_combiner (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .lo_smp(lo_smp), .hi_smp(hi_smp),
        .out_valid(out_valid), .sample(sample)
    );

    function automatic int model(int m, int lo, int hi);
        int a, b1, b2, c, b, v;
        a = lo / 16; b1 = lo % 16; b2 = hi / 16; c = hi % 16;
        if (m == 0) return a * 256 + hi;
        if (b1 >= 12 && b2 < 4)      b = (b1 + b2 + 16) / 2;
        else if (b1 < 4 && b2 >= 12) b = (b1 + b2 - 16) / 2;
        else                         b = (b1 + b2) / 2;
        v = a * 256 + b * 16 + c;
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return v;
    endfunction

    function automatic string tag_of(int m, int lo, int hi);
        int a, b1, b2, c, raw, b;
        a = lo / 16; b1 = lo % 16; b2 = hi / 16; c = hi % 16;
        if (m == 0) return "R3";
        if (b1 >= 12 && b2 < 4)      b = (b1 + b2 + 16) / 2;
        else if (b1 < 4 && b2 >= 12) b = (b1 + b2 - 16) / 2;
        else                         b = (b1 + b2) / 2;
        raw = a * 256 + b * 16 + c;
        if (raw < 0 || raw > 4095) return "R8";
        if (b < 0 || b > 15) return "R7";
        if (b1 >= 12 && b2 < 4) return "R5";
        if (b1 < 4 && b2 >= 12) return "R6";
        return "R4";
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(int m, int lo, int hi, int exp, string tag);
        @(negedge clk);
        in_valid = 1'b1; mode = m[0]; lo_smp = lo[7:0]; hi_smp = hi[7:0];
        @(negedge clk);
        check("R2", int'(out_valid), 1);
        check(tag, int'(sample), exp);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int    exp_prev;
        string tag_prev;
        logic  have_prev;
        logic [11:0] held;
        have_prev = 1'b0;
        exp_prev  = 0;
        tag_prev  = "";

        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(sample), 0);

        // directed corners
        apply(1, 8'h96, 8'h9B, 12'h97B, "R4");
        apply(1, 8'h3D, 8'h25, 12'h3F5, "R5");
        apply(1, 8'h52, 8'hE7, 12'h507, "R6");
        apply(1, 8'h51, 8'hC9, 12'h4F9, "R6");   // -3/2 -> -1
        apply(1, 8'h4F, 8'h3A, 12'h51A, "R7");
        apply(1, 8'h00, 8'hC0, 12'h000, "R8");
        apply(1, 8'hFF, 8'h3F, 12'hFFF, "R8");
        apply(0, 8'hA7, 8'h5C, 12'hA5C, "R3");

        // idle cycle with altered data: output held
        @(negedge clk);
        held = sample;
        in_valid = 1'b0; mode = 1'b1; lo_smp = 8'h12; hi_smp = 8'h34;
        @(negedge clk);
        check("R9", int'(sample), int'(held));
        check("R2", int'(out_valid), 0);
        @(negedge clk);
        check("R9", int'(sample), int'(held));

        // exhaustive sweep in both modes, streamed back to back
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 65536; i++) begin
                @(negedge clk);
                if (have_prev) begin
                    check("R2", int'(out_valid), 1);
                    check(tag_prev, int'(sample), exp_prev);
                end
                in_valid = 1'b1;
                mode     = m[0];
                lo_smp   = i[15:8];
                hi_smp   = i[7:0];
                exp_prev = model(m, i / 256, i % 256);
                tag_prev = tag_of(m, i / 256, i % 256);
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        check("R2", int'(out_valid), 1);
        check(tag_prev, int'(sample), exp_prev);
        in_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule